// File: doc/BRIEF.md
# Register Rename Map with History Rollback

This block keeps the speculative mapping from architectural to physical registers for an out-of-order core. It recovers from mispredictions by undoing renames one at a time rather than by restoring saved copies of the map. It contains three parts: a map table, a bitmap of free physical registers, and a circular log of renames. Each log entry holds the instruction's sequence number, the architectural destination, the newly granted physical register, and the physical register that was mapped before.

The rename stage presents one destination per cycle and receives the new and previous physical registers in the same cycle. A source operand can be translated at any time through a separate lookup port.

Retirement gives a sequence tag. Entries are then drained from the old end of the log, and each one hands its displaced register back to the free pool. A squash tag makes the block walk the log from the young end. For each entry it puts the previous mapping back and returns the granted register. The walk handles one entry per clock and holds `busy` high while it runs. A flush request walks back every entry in the log.

Top module: `rename_rollback_unit`

## Requirements
- R1: After reset, architectural register a maps to physical register a. Physical registers NUM_ARCH to NUM_PHYS-1 are free, `free_level` equals NUM_PHYS-NUM_ARCH, `busy` is low and `ren_ready` is high.
- R2: A rename accepted at a clock edge (`ren_valid` and `ren_ready`, with no squash or flush) behaves as follows. `ren_new_phys` is the lowest-numbered free physical register. `ren_prev_phys` is the register currently mapped to `ren_arch`. After the edge the map points `ren_arch` at the new register, which is no longer free. Accepted sequence numbers must strictly increase, compared as unsigned numbers with no wraparound.
- R3: `src_phys` combinationally shows the current mapping of `src_arch`.
- R4: `ren_ready` is low while `busy` is high or no physical register is free. A `ren_valid` presented while `ren_ready` is low changes nothing.
- R5: A squash with tag S raises `busy` from the next cycle. Each following clock removes the youngest entry if its sequence is greater than S. Removing an entry restores that entry's previous mapping and frees its new register. `busy` stays high for k+1 cycles when k entries are removed.
- R6: A squash with an empty log keeps `busy` high for exactly one cycle and changes no mapping and no free register.
- R7: A commit with tag C removes entries from the old end, one per clock, while their sequence is at most C. Each removed entry frees its previous register, and its mapping stays in place.
- R8: A commit whose tag is lower than the oldest entry's sequence, or that arrives when the log is empty, has no effect.
- R9: A commit presented in the same cycle as a squash or flush, or while `busy` is high, is ignored.
- R10: A flush walks back every log entry, youngest first, one per clock. Afterwards all NUM_PHYS-NUM_ARCH spare registers are free again and the map holds the mapping from before every logged rename.
- R11: A rename presented in the same cycle as a squash or flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request for one destination |
| ren_arch | input | ARCH_W | Architectural destination register |
| ren_seq | input | SEQ_W | Sequence number of the renaming instruction |
| ren_ready | output | 1 | A rename can be accepted this cycle |
| ren_new_phys | output | PHYS_W | Physical register granted to the destination |
| ren_prev_phys | output | PHYS_W | Physical register displaced from the map |
| src_arch | input | ARCH_W | Architectural source register to translate |
| src_phys | output | PHYS_W | Current physical register of `src_arch` |
| cmt_valid | input | 1 | Retirement tag valid |
| cmt_seq | input | SEQ_W | Youngest retired sequence number |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Youngest surviving sequence number |
| flush | input | 1 | Roll back every logged rename |
| busy | output | 1 | Rollback walk in progress |
| free_level | output | LVL_W | Number of free physical registers |

## Verification
A corrupted log entry shows up in one of two ways. It can restore a wrong mapping, which `src_phys` exposes on the first lookup after the walk. It can free a wrong register, which makes a later `ren_new_phys` differ from the lowest free index at the next allocation. A walk that stops too early or runs too long changes how many cycles `busy` stays high, and this is visible as soon as the walk ends. A register that leaks or is freed twice shifts `free_level` in the cycle after the faulty removal. It is also caught internally by the rule that free registers plus log entries always equal the number of spare registers.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
   typedef enum logic [1:0] {
      RB_IDLE   = 2'd0,
      RB_SQUASH = 2'd1,
      RB_FLUSH  = 2'd2
   } rb_mode_e;
endpackage

// File: rtl/rhb_freelist.sv
module rhb_freelist #(
   parameter int NUM_PHYS = 16,
   parameter int NUM_ARCH = 8,
   localparam int PW = $clog2(NUM_PHYS),
   localparam int LW = $clog2(NUM_PHYS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc_en,
   output logic [PW-1:0] alloc_idx,
   output logic          has_free,
   input  logic          rel_en,
   input  logic [PW-1:0] rel_idx,
   output logic [LW-1:0] level
);
   logic [NUM_PHYS-1:0] free_q;

   // lowest free index wins
   always_comb begin
      alloc_idx = '0;
      for (int i = NUM_PHYS - 1; i >= 0; i--) begin
         if (free_q[i]) alloc_idx = PW'(i);
      end
   end

   assign has_free = |free_q;

   always_comb begin
      level = '0;
      for (int i = 0; i < NUM_PHYS; i++) level = level + LW'(free_q[i]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_PHYS; i++) free_q[i] <= (i >= NUM_ARCH);
      end else begin
         if (alloc_en) free_q[alloc_idx] <= 1'b0;
         if (rel_en)   free_q[rel_idx]   <= 1'b1;
      end
   end

   assert_alloc_has_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> has_free);
   assert_no_double_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rel_en |-> !free_q[rel_idx]);
   assert_alloc_release_distinct_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_en && rel_en) |-> (alloc_idx != rel_idx));
endmodule

// File: rtl/rhb_maptable.sv
module rhb_maptable #(
   parameter int NUM_ARCH = 8,
   parameter int NUM_PHYS = 16,
   localparam int AW = $clog2(NUM_ARCH),
   localparam int PW = $clog2(NUM_PHYS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] rd_a_arch,
   output logic [PW-1:0] rd_a_phys,
   input  logic [AW-1:0] rd_b_arch,
   output logic [PW-1:0] rd_b_phys,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_arch,
   input  logic [PW-1:0] wr_phys
);
   logic [PW-1:0] map_q [NUM_ARCH];

   assign rd_a_phys = map_q[rd_a_arch];
   assign rd_b_phys = map_q[rd_b_arch];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < NUM_ARCH; a++) map_q[a] <= PW'(a);
      end else if (wr_en) begin
         map_q[wr_arch] <= wr_phys;
      end
   end

   assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_b_arch == wr_arch) |=> ($past(rd_b_arch) != rd_b_arch) || (rd_b_phys == $past(wr_phys)));
endmodule

// File: rtl/rhb_history.sv
module rhb_history #(
   parameter int DEPTH    = 8,
   parameter int SEQ_W    = 8,
   parameter int NUM_ARCH = 8,
   parameter int NUM_PHYS = 16,
   localparam int AW = $clog2(NUM_ARCH),
   localparam int PW = $clog2(NUM_PHYS),
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [SEQ_W-1:0] push_seq,
   input  logic [AW-1:0]    push_arch,
   input  logic [PW-1:0]    push_new,
   input  logic [PW-1:0]    push_prev,
   input  logic             pop_young,
   input  logic             pop_old,
   output logic [SEQ_W-1:0] young_seq,
   output logic [AW-1:0]    young_arch,
   output logic [PW-1:0]    young_new,
   output logic [PW-1:0]    young_prev,
   output logic [SEQ_W-1:0] old_seq,
   output logic [PW-1:0]    old_prev,
   output logic             empty,
   output logic             full,
   output logic [CW-1:0]    count
);
   logic [SEQ_W-1:0] seq_q  [DEPTH];
   logic [AW-1:0]    arch_q [DEPTH];
   logic [PW-1:0]    new_q  [DEPTH];
   logic [PW-1:0]    prev_q [DEPTH];
   logic [IW-1:0]    head_q, tail_q, young_idx;

   function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] p);
      return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign young_idx  = (tail_q == '0) ? IW'(DEPTH - 1) : tail_q - 1'b1;
   assign young_seq  = seq_q[young_idx];
   assign young_arch = arch_q[young_idx];
   assign young_new  = new_q[young_idx];
   assign young_prev = prev_q[young_idx];
   assign old_seq    = seq_q[head_q];
   assign old_prev   = prev_q[head_q];
   assign empty      = (count == '0);
   assign full       = (count == CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (push) begin
         seq_q[tail_q]  <= push_seq;
         arch_q[tail_q] <= push_arch;
         new_q[tail_q]  <= push_new;
         prev_q[tail_q] <= push_prev;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         count  <= '0;
      end else begin
         if (push)           tail_q <= wrap_inc(tail_q);
         else if (pop_young) tail_q <= young_idx;
         if (pop_old)        head_q <= wrap_inc(head_q);
         count <= count + CW'(push) - CW'(pop_young) - CW'(pop_old);
      end
   end

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop_old) |-> !full);
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_young || pop_old) |-> !empty);
   assert_single_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop_young && (pop_old || push)));
endmodule

// File: rtl/rename_rollback_unit.sv
module rename_rollback_unit #(
   parameter int NUM_ARCH   = 8,
   parameter int NUM_PHYS   = 16,
   parameter int SEQ_W      = 8,
   parameter int HIST_DEPTH = NUM_PHYS - NUM_ARCH,
   localparam int ARCH_W = $clog2(NUM_ARCH),
   localparam int PHYS_W = $clog2(NUM_PHYS),
   localparam int LVL_W  = $clog2(NUM_PHYS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ren_valid,
   input  logic [ARCH_W-1:0] ren_arch,
   input  logic [SEQ_W-1:0]  ren_seq,
   output logic              ren_ready,
   output logic [PHYS_W-1:0] ren_new_phys,
   output logic [PHYS_W-1:0] ren_prev_phys,
   input  logic [ARCH_W-1:0] src_arch,
   output logic [PHYS_W-1:0] src_phys,
   input  logic              cmt_valid,
   input  logic [SEQ_W-1:0]  cmt_seq,
   input  logic              sq_valid,
   input  logic [SEQ_W-1:0]  sq_seq,
   input  logic              flush,
   output logic              busy,
   output logic [LVL_W-1:0]  free_level
);
   import rhb_pkg::*;

   localparam int SPARE = NUM_PHYS - NUM_ARCH;
   localparam int HCW   = $clog2(HIST_DEPTH + 1);

   if (NUM_ARCH < 2) begin : g_bad_arch
      $error("NUM_ARCH must be at least 2");
   end
   if (NUM_PHYS <= NUM_ARCH) begin : g_bad_phys
      $error("NUM_PHYS must exceed NUM_ARCH");
   end
   if (HIST_DEPTH < 1) begin : g_bad_depth
      $error("HIST_DEPTH must be at least 1");
   end

   rb_mode_e         mode_q;
   logic [SEQ_W-1:0] sq_tag_q, cmt_lim_q;
   logic             cmt_go_q;

   logic              fl_has_free;
   logic [PHYS_W-1:0] fl_alloc_idx, rel_idx;
   logic              rel_en;
   logic              h_empty, h_full;
   logic [HCW-1:0]    h_count;
   logic [SEQ_W-1:0]  h_young_seq, h_old_seq;
   logic [ARCH_W-1:0] h_young_arch;
   logic [PHYS_W-1:0] h_young_new, h_young_prev, h_old_prev;
   logic              start_rb, ren_fire, walk_pop, cmt_pop, take_cmt;
   logic              map_wr_en;
   logic [ARCH_W-1:0] map_wr_arch;
   logic [PHYS_W-1:0] map_wr_phys;

   assign busy      = (mode_q != RB_IDLE);
   assign start_rb  = sq_valid || flush;
   assign ren_ready = !busy && fl_has_free && !h_full;
   assign ren_fire  = ren_valid && ren_ready && !start_rb;
   assign ren_new_phys = fl_alloc_idx;

   assign walk_pop = busy && !h_empty &&
                     ((mode_q == RB_FLUSH) || (h_young_seq > sq_tag_q));
   assign take_cmt = cmt_valid && !start_rb && !busy;
   assign cmt_pop  = cmt_go_q && !busy && !start_rb && !h_empty &&
                     (h_old_seq <= cmt_lim_q);

   assign rel_en  = walk_pop || cmt_pop;
   assign rel_idx = walk_pop ? h_young_new : h_old_prev;

   assign map_wr_en   = ren_fire || walk_pop;
   assign map_wr_arch = walk_pop ? h_young_arch : ren_arch;
   assign map_wr_phys = walk_pop ? h_young_prev : fl_alloc_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= RB_IDLE;
         sq_tag_q <= '0;
      end else if (start_rb) begin
         mode_q   <= flush ? RB_FLUSH : RB_SQUASH;
         sq_tag_q <= sq_seq;
      end else if (busy && !walk_pop) begin
         mode_q   <= RB_IDLE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmt_go_q  <= 1'b0;
         cmt_lim_q <= '0;
      end else if (start_rb) begin
         cmt_go_q  <= 1'b0;
      end else if (take_cmt) begin
         cmt_go_q  <= 1'b1;
         cmt_lim_q <= cmt_seq;
      end else if (cmt_go_q && !busy && !cmt_pop) begin
         cmt_go_q  <= 1'b0;
      end
   end

   rhb_freelist #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH)) u_free (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(ren_fire), .alloc_idx(fl_alloc_idx), .has_free(fl_has_free),
      .rel_en(rel_en), .rel_idx(rel_idx), .level(free_level)
   );

   rhb_maptable #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
      .clk(clk), .rst_n(rst_n),
      .rd_a_arch(src_arch), .rd_a_phys(src_phys),
      .rd_b_arch(ren_arch), .rd_b_phys(ren_prev_phys),
      .wr_en(map_wr_en), .wr_arch(map_wr_arch), .wr_phys(map_wr_phys)
   );

   rhb_history #(.DEPTH(HIST_DEPTH), .SEQ_W(SEQ_W), .NUM_ARCH(NUM_ARCH),
                 .NUM_PHYS(NUM_PHYS)) u_hist (
      .clk(clk), .rst_n(rst_n),
      .push(ren_fire), .push_seq(ren_seq), .push_arch(ren_arch),
      .push_new(fl_alloc_idx), .push_prev(ren_prev_phys),
      .pop_young(walk_pop), .pop_old(cmt_pop),
      .young_seq(h_young_seq), .young_arch(h_young_arch),
      .young_new(h_young_new), .young_prev(h_young_prev),
      .old_seq(h_old_seq), .old_prev(h_old_prev),
      .empty(h_empty), .full(h_full), .count(h_count)
   );

   // every spare register is either free or held by exactly one log entry
   assert_conserve_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(free_level) + int'(h_count)) == SPARE);
   assert_log_records_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ren_fire |=> (h_young_seq == $past(ren_seq)) && (h_young_new == $past(fl_alloc_idx)));
   assert_seq_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ren_fire && !h_empty) |-> (ren_seq > h_young_seq));
   assert_walk_complete_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (h_empty || ($past(mode_q) == RB_SQUASH && h_young_seq <= sq_tag_q)));
   assert_no_rename_in_walk_R11: assert property (@(posedge clk) disable iff (!rst_n)
      start_rb |=> $stable(free_level) || busy);
endmodule

// File: tb/rename_rollback_unit_test.sv
module rename_rollback_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int NA = 8;
   localparam int NP = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ren_valid = 1'b0;
   logic [2:0] ren_arch = '0;
   logic [7:0] ren_seq = '0;
   logic       ren_ready;
   logic [3:0] ren_new_phys, ren_prev_phys;
   logic [2:0] src_arch = '0;
   logic [3:0] src_phys;
   logic       cmt_valid = 1'b0;
   logic [7:0] cmt_seq = '0;
   logic       sq_valid = 1'b0;
   logic [7:0] sq_seq = '0;
   logic       flush = 1'b0;
   logic       busy;
   logic [4:0] free_level;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   int mmap [NA];
   bit mfree [NP];
   int q_seq[$], q_arch[$], q_new[$], q_prev[$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   rename_rollback_unit uut (
      .clk(clk), .rst_n(rst_n),
      .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_seq(ren_seq),
      .ren_ready(ren_ready), .ren_new_phys(ren_new_phys), .ren_prev_phys(ren_prev_phys),
      .src_arch(src_arch), .src_phys(src_phys),
      .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
      .sq_valid(sq_valid), .sq_seq(sq_seq), .flush(flush),
      .busy(busy), .free_level(free_level)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int model_lowest_free();
      for (int i = 0; i < NP; i++) if (mfree[i]) return i;
      return -1;
   endfunction

   function automatic int model_free_count();
      int c = 0;
      for (int i = 0; i < NP; i++) c += int'(mfree[i]);
      return c;
   endfunction

   function automatic int model_squash(input int s, input bit all);
      int k = 0;
      while (q_seq.size() > 0 && (all || q_seq[q_seq.size()-1] > s)) begin
         mmap[q_arch[q_arch.size()-1]] = q_prev[q_prev.size()-1];
         mfree[q_new[q_new.size()-1]] = 1'b1;
         void'(q_seq.pop_back()); void'(q_arch.pop_back());
         void'(q_new.pop_back()); void'(q_prev.pop_back());
         k++;
      end
      return k;
   endfunction

   function automatic void model_commit(input int c);
      while (q_seq.size() > 0 && q_seq[0] <= c) begin
         mfree[q_prev[0]] = 1'b1;
         void'(q_seq.pop_front()); void'(q_arch.pop_front());
         void'(q_new.pop_front()); void'(q_prev.pop_front());
      end
   endfunction

   // R3 lookup of every register, plus free level and idle state
   task automatic check_state(input string tag);
      for (int a = 0; a < NA; a++) begin
         src_arch = 3'(a);
         #1;
         chk({tag, " R3 map"}, int'(src_phys), mmap[a]);
      end
      chk({tag, " free_level"}, int'(free_level), model_free_count());
      chk({tag, " busy idle"}, int'(busy), 0);
   endtask

   task automatic do_rename(input int arch, input int seq);
      @(negedge clk);
      ren_valid = 1'b1; ren_arch = 3'(arch); ren_seq = 8'(seq);
      #1;
      chk("R2 ready", int'(ren_ready), 1);
      chk("R2 new phys", int'(ren_new_phys), model_lowest_free());
      chk("R2 prev phys", int'(ren_prev_phys), mmap[arch]);
      @(posedge clk);
      q_seq.push_back(seq); q_arch.push_back(arch);
      q_new.push_back(model_lowest_free()); q_prev.push_back(mmap[arch]);
      mmap[arch] = model_lowest_free();
      mfree[q_new[q_new.size()-1]] = 1'b0;
      @(negedge clk);
      ren_valid = 1'b0;
   endtask

   task automatic count_busy(output int n);
      n = 0;
      while (busy && n < 100) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_squash(input string tag, input int s, input bit all, input int exp_busy);
      int n;
      int k;
      @(negedge clk);
      sq_valid = !all; flush = all; sq_seq = 8'(s);
      @(posedge clk);
      @(negedge clk);
      sq_valid = 1'b0; flush = 1'b0;
      count_busy(n);
      k = model_squash(s, all);
      chk({tag, " busy cycles"}, n, exp_busy);
      chk({tag, " entries removed"}, k + 1, exp_busy);
      check_state(tag);
   endtask

   task automatic do_commit(input string tag, input int c);
      @(negedge clk);
      cmt_valid = 1'b1; cmt_seq = 8'(c);
      @(negedge clk);
      cmt_valid = 1'b0;
      repeat (NP + 2) @(negedge clk);
      model_commit(c);
      check_state(tag);
   endtask

   task automatic t_reset();
      for (int a = 0; a < NA; a++) mmap[a] = a;
      for (int p = 0; p < NP; p++) mfree[p] = (p >= NA);
      @(negedge clk);
      chk("R1 ready", int'(ren_ready), 1);
      chk("R1 free_level", int'(free_level), NP - NA);
      check_state("R1 reset");
   endtask

   task automatic t_basic_rename();
      do_rename(2, 1); do_rename(5, 2); do_rename(2, 3);
      do_rename(7, 4); do_rename(0, 5);
      check_state("R2 after renames");
   endtask

   task automatic t_commit_cases();
      do_commit("R8 commit older tag", 0);
      do_commit("R7 commit two", 2);
   endtask

   task automatic t_commit_with_squash();
      int n;
      int k;
      do_rename(4, 6); do_rename(1, 7);
      @(negedge clk);
      cmt_valid = 1'b1; cmt_seq = 8'd10; sq_valid = 1'b1; sq_seq = 8'd6;
      @(posedge clk);
      @(negedge clk);
      cmt_valid = 1'b0; sq_valid = 1'b0;
      count_busy(n);
      repeat (4) @(negedge clk);
      k = model_squash(6, 1'b0);
      chk("R9 busy cycles", n, 2);
      chk("R9 removed one", k, 1);
      check_state("R9 commit dropped on squash");
   endtask

   task automatic t_rename_with_squash();
      int n;
      @(negedge clk);
      ren_valid = 1'b1; ren_arch = 3'd3; ren_seq = 8'd8;
      sq_valid = 1'b1; sq_seq = 8'd100;
      @(posedge clk);
      @(negedge clk);
      ren_valid = 1'b0; sq_valid = 1'b0;
      count_busy(n);
      chk("R11 busy cycles", n, 1);
      check_state("R11 rename dropped");
   endtask

   task automatic t_fill();
      int seq = 30;
      int room = NP - NA - q_seq.size();
      int made = 0;
      while (ren_ready && made < NP) begin
         do_rename(made % NA, seq);
         seq++; made++;
      end
      chk("R4 renames until empty", made, room);
      chk("R4 free_level zero", int'(free_level), 0);
      @(negedge clk);
      ren_valid = 1'b1; ren_arch = 3'd1; ren_seq = 8'd60;
      #1;
      chk("R4 ready low", int'(ren_ready), 0);
      @(posedge clk);
      @(negedge clk);
      ren_valid = 1'b0;
      check_state("R4 rename ignored");
   endtask

   task automatic t_commit_while_busy();
      int n;
      int k;
      do_rename(6, 20); do_rename(3, 21); do_rename(6, 22);
      @(negedge clk);
      sq_valid = 1'b1; sq_seq = 8'd20;
      @(posedge clk);
      @(negedge clk);
      sq_valid = 1'b0; cmt_valid = 1'b1; cmt_seq = 8'd50;
      chk("R9 busy during commit", int'(busy), 1);
      @(posedge clk);
      @(negedge clk);
      cmt_valid = 1'b0;
      count_busy(n);
      n++;
      repeat (NP + 2) @(negedge clk);
      k = model_squash(20, 1'b0);
      chk("R5 busy cycles", n, 3);
      chk("R5 removed two", k, 2);
      check_state("R9 commit ignored while busy");
      do_commit("R7 late commit", 20);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic_rename();
      do_squash("R5 squash", 3, 1'b0, 3);
      t_commit_cases();
      t_commit_with_squash();
      t_rename_with_squash();
      t_fill();
      do_squash("R10 flush", 0, 1'b1, NP - NA + 1);
      chk("R10 all spare free", int'(free_level), NP - NA);
      do_squash("R6 empty squash", 0, 1'b0, 1);
      t_commit_while_busy();
      do_commit("R8 commit empty log", 200);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end
endmodule